// File: doc/BRIEF.md
# Palette-Indexed Pixel Serializer

This block turns a stream of video bytes into one colour per pixel clock without a shift register. A small column counter runs across each visible line. The palette select, the current data byte and the three column bits are joined into a palette address. The palette memory returns an 8-bit colour, which is registered before it leaves the block. The palette entry packs green in bits [7:5], red in [4:2] and blue in [1:0]. The selected bit depth (1, 2, 4 or 8 bits per pixel) depends only on what software has written into the palette. For example, a 1bpp table makes column n pick data bit n. An 8bpp table repeats the same colour for every column value.

The block asks its byte source for a new byte through a load strobe. In text mode the strobe comes once per 8 active pixel clocks. In graphics mode it comes once per 4. A line-start pulse clears the column counter and captures the first byte of the line. A CPU port writes palette entries. A write made during blanking lands at once. A write made during active video is parked in a single holding slot and retires on the first blanking cycle, so the current line is never disturbed. The palette select width is a parameter. It defaults to 1 bit to keep the default memory small, and 4 bits gives the full 15-bit address.

Top module: `pal_pixel_serializer`

## Requirements
- R1: The palette read address is {pal_sel, data byte, column[2:0]}, from most to least significant. The colour for the pixel clock at column c appears on color_out one cycle later. A different pal_sel selects a different table.
- R2: After any cycle with blank high, color_out is 0 in the following cycle.
- R3: A cycle with line_start high asserts byte_load in that same cycle. It captures byte_in as the current byte, and the next active cycle uses column 0.
- R4: In text mode (text_mode=1), byte_load is asserted on every active cycle at column 7, so a new byte arrives every 8 active cycles. byte_in is ignored in all other cycles.
- R5: In graphics mode (text_mode=0), byte_load is asserted on every active cycle at columns 3 and 7, so a new byte arrives every 4 active cycles.
- R6: With a 1bpp table, where the entry is 8'hFF when data bit c is 1 and 8'h00 otherwise, column c shows the state of bit c of the byte.
- R7: With a 2bpp table, where the entry is a 4-colour lookup of bits [2k+1:2k] with k = column[2:1], each bit pair fills two adjacent pixels.
- R8: With an 8bpp table, where the entry depends only on the byte, the column bits have no effect and each byte fills all of its 4 graphics pixels with one colour.
- R9: A CPU write made while blank is high updates the palette at that clock edge, and the next line uses the new value.
- R10: A CPU write made while blank is low does not change the palette during that active period. It takes effect on the first blank cycle that follows.
- R11: At most one write is held. A later write during the same active period replaces the held one, and the earlier write is discarded.
- R12: If a write arrives on the first blank cycle while a held write is pending, the held write retires in that cycle and the new write retires in the next blank cycle. Both are then visible.
- R13: After reset, color_out is 0 and byte_load is 0 while line_start is low and blank is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Start-of-visible-line pulse; clears the column and loads the first byte |
| blank | input | 1 | High outside the visible area; forces black and opens the palette to writes |
| text_mode | input | 1 | 1: byte every 8 pixels, 0: byte every 4 pixels |
| pal_sel | input | PSEL_W | Palette table select, top address bits |
| byte_in | input | 8 | Video byte from the source, captured when byte_load is high |
| cpu_we | input | 1 | Palette write strobe |
| cpu_addr | input | PSEL_W+11 | Palette write address {select, byte, column} |
| cpu_wdata | input | 8 | Palette entry to write |
| byte_load | output | 1 | Byte capture strobe for the byte source |
| color_out | output | 8 | Registered pixel colour, G[7:5] R[4:2] B[1:0] |

## Verification
The hardest case to reach from the ports is a palette write that arrives mid-line while another write is already parked, or that arrives on the very first blanking cycle. The ordering rule is visible there only if the affected entries are read again. The stimulus issues writes at chosen pixel positions inside a line. It targets entries that the same line reads a few pixels later, so a premature write would show at once. It then repeats the same byte sequence on the next line to prove which write survived. A write on the line's closing blank cycle is combined with an earlier mid-line write to exercise the back-to-back retirement.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam int BYTE_W  = 8;
    localparam int COLOR_W = 8;

    typedef logic [BYTE_W-1:0]  vbyte_t;
    typedef logic [COLOR_W-1:0] color_t;

    localparam color_t COLOR_BLANK = '0;
endpackage

// File: rtl/pps_palette_ram.sv
module pps_palette_ram #(
    parameter int AW = 12,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pps_column_ctrl.sv
module pps_column_ctrl
    import pps_pkg::*;
#(
    parameter int TEXT_SPAN = 8,
    parameter int GFX_SPAN  = 4,
    localparam int COL_W = $clog2(TEXT_SPAN),
    localparam int GFX_W = $clog2(GFX_SPAN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             blank,
    input  logic             text_mode,
    input  vbyte_t           byte_in,
    output logic [COL_W-1:0] col,
    output vbyte_t           cur_byte,
    output logic             byte_load
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        vbyte_t           data;
    } colst_t;

    colst_t s_d, s_q;
    logic   load_d;

    always_comb begin
        s_d    = s_q;
        load_d = 1'b0;
        if (line_start) begin
            s_d.col = '0;
            load_d  = 1'b1;
        end else if (!blank) begin
            s_d.col = s_q.col + 1'b1;
            if (text_mode) begin
                load_d = (s_q.col == COL_W'(TEXT_SPAN - 1));
            end else begin
                load_d = (s_q.col[GFX_W-1:0] == GFX_W'(GFX_SPAN - 1));
            end
        end
        if (load_d) begin
            s_d.data = byte_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign col       = s_q.col;
    assign cur_byte  = s_q.data;
    assign byte_load = load_d;
endmodule

// File: rtl/pps_write_hold.sv
module pps_write_hold #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blank,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          pending
);
    typedef struct packed {
        logic          pend;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d       = h_q;
        ram_we    = 1'b0;
        ram_addr  = cpu_addr;
        ram_wdata = cpu_wdata;
        if (blank) begin
            if (h_q.pend) begin
                // parked write goes first, a new one takes the slot
                ram_we    = 1'b1;
                ram_addr  = h_q.addr;
                ram_wdata = h_q.data;
                h_d.pend  = cpu_we;
                if (cpu_we) begin
                    h_d.addr = cpu_addr;
                    h_d.data = cpu_wdata;
                end
            end else if (cpu_we) begin
                ram_we = 1'b1;
            end
        end else if (cpu_we) begin
            h_d.pend = 1'b1;
            h_d.addr = cpu_addr;
            h_d.data = cpu_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign pending = h_q.pend;
endmodule

// File: rtl/pal_pixel_serializer.sv
module pal_pixel_serializer
    import pps_pkg::*;
#(
    parameter int PSEL_W    = 1,
    parameter int TEXT_SPAN = 8,
    parameter int GFX_SPAN  = 4,
    localparam int COL_W = $clog2(TEXT_SPAN),
    localparam int AW    = PSEL_W + BYTE_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              blank,
    input  logic              text_mode,
    input  logic [PSEL_W-1:0] pal_sel,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [COLOR_W-1:0] cpu_wdata,
    output logic              byte_load,
    output logic [COLOR_W-1:0] color_out
);
    typedef struct packed {
        color_t color;
    } outst_t;

    logic [COL_W-1:0] col;
    vbyte_t           cur_byte;
    logic             ram_we;
    logic [AW-1:0]    ram_waddr;
    color_t           ram_wdata;
    logic             hold_pending;
    logic [AW-1:0]    rd_addr;
    color_t           rd_color;
    outst_t           o_d, o_q;

    pps_column_ctrl #(
        .TEXT_SPAN (TEXT_SPAN),
        .GFX_SPAN  (GFX_SPAN)
    ) u_col (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .blank      (blank),
        .text_mode  (text_mode),
        .byte_in    (byte_in),
        .col        (col),
        .cur_byte   (cur_byte),
        .byte_load  (byte_load)
    );

    pps_write_hold #(
        .AW (AW),
        .DW (COLOR_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .blank     (blank),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .ram_we    (ram_we),
        .ram_addr  (ram_waddr),
        .ram_wdata (ram_wdata),
        .pending   (hold_pending)
    );

    assign rd_addr = {pal_sel, cur_byte, col};

    pps_palette_ram #(
        .AW (AW),
        .DW (COLOR_W)
    ) u_pal (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (rd_addr),
        .rdata (rd_color)
    );

    always_comb begin
        o_d       = o_q;
        o_d.color = blank ? COLOR_BLANK : rd_color;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign color_out = o_q.color;
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
    parameter int TEXT_SPAN = 8,
    parameter int GFX_SPAN  = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       line_start,
    input logic       blank,
    input logic       text_mode,
    input logic       byte_load,
    input logic [7:0] color_out,
    input logic       ram_we,
    input logic       hold_pending
);
    localparam int CW = $clog2(TEXT_SPAN) + 1;

    logic [CW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (byte_load) begin
            gap_q <= '0;
        end else if (!blank) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R2
    blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (color_out == 8'h00));

    // R4 R5
    load_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_load && !line_start) |->
            (gap_q == (text_mode ? CW'(TEXT_SPAN - 1) : CW'(GFX_SPAN - 1))));

    // R10
    no_write_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |-> !ram_we);

    // R12
    flush_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && hold_pending) |-> ram_we);
endmodule

bind pal_pixel_serializer pps_checker #(
    .TEXT_SPAN (TEXT_SPAN),
    .GFX_SPAN  (GFX_SPAN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start   (line_start),
    .blank        (blank),
    .text_mode    (text_mode),
    .byte_load    (byte_load),
    .color_out    (color_out),
    .ram_we       (ram_we),
    .hold_pending (hold_pending)
);

// File: tb/pal_pixel_serializer_tb.sv
module pal_pixel_serializer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PSEL_W = 1;
    localparam int AW = PSEL_W + 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_start = 1'b0;
    logic              blank = 1'b1;
    logic              text_mode = 1'b1;
    logic [PSEL_W-1:0] pal_sel = '0;
    logic [7:0]        byte_in = 8'h00;
    logic              cpu_we = 1'b0;
    logic [AW-1:0]     cpu_addr = '0;
    logic [7:0]        cpu_wdata = 8'h00;
    logic              byte_load;
    logic [7:0]        color_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] shadow [1 << AW];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       mon_en = 1'b0;
    logic       mon_take;

    pal_pixel_serializer #(.PSEL_W(PSEL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .blank(blank),
        .text_mode(text_mode), .pal_sel(pal_sel), .byte_in(byte_in),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .byte_load(byte_load), .color_out(color_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: pops one expected colour per flagged cycle
    always @(posedge clk) begin
        mon_take = mon_en;
        #1;
        if (mon_take) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", 8'h01, 8'h00);
            end else begin
                chk(tag_q.pop_front(), color_out, exp_q.pop_front());
            end
        end
    end

    function automatic logic [AW-1:0] mk_addr(input logic [PSEL_W-1:0] s,
                                             input logic [7:0] b, input int c);
        return {s, b, 3'(c)};
    endfunction

    function automatic logic [7:0] byte_of(input logic [7:0] seed, input int k);
        return seed + 8'(k * 37);
    endfunction

    task automatic cyc(input logic ls, input logic bl, input logic [7:0] b,
                       input logic we, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic want, input logic [7:0] exp, input string tag);
        @(negedge clk);
        line_start = ls; blank = bl; byte_in = b;
        cpu_we = we; cpu_addr = a; cpu_wdata = d;
        mon_en = want;
        if (want) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
    endtask

    task automatic pal_write(input logic [AW-1:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b1, 8'h00, 1'b1, a, d, 1'b0, 8'h00, "");
        shadow[a] = d;
    endtask

    task automatic fill_1bpp(input logic [PSEL_W-1:0] s);
        for (int b = 0; b < 256; b++)
            for (int c = 0; c < 8; c++)
                pal_write(mk_addr(s, 8'(b), c), ((b >> c) & 1) != 0 ? 8'hFF : 8'h00);
    endtask

    task automatic fill_8bpp(input logic [PSEL_W-1:0] s);
        for (int b = 0; b < 256; b++)
            for (int c = 0; c < 8; c++)
                pal_write(mk_addr(s, 8'(b), c), 8'(b) ^ 8'h5A);
    endtask

    task automatic fill_2bpp(input logic [PSEL_W-1:0] s);
        logic [7:0] lut [4];
        lut[0] = 8'h03; lut[1] = 8'h1C; lut[2] = 8'hE0; lut[3] = 8'hFF;
        for (int b = 0; b < 256; b++)
            for (int c = 0; c < 8; c++)
                pal_write(mk_addr(s, 8'(b), c), lut[(b >> (2 * (c / 2))) & 3]);
    endtask

    task automatic run_line(input logic tm, input logic [PSEL_W-1:0] sel,
                            input int nbytes, input logic [7:0] seed, input string tag,
                            input int wa_at, input logic [AW-1:0] wa_addr, input logic [7:0] wa_data,
                            input int wb_at, input logic [AW-1:0] wb_addr, input logic [7:0] wb_data,
                            input logic tail_we, input logic [AW-1:0] tail_addr,
                            input logic [7:0] tail_data);
        logic [7:0] cur;
        int k;
        int ncyc;
        string ldtag;
        ldtag = tm ? "R4 byte_load" : "R5 byte_load";
        ncyc = nbytes * (tm ? 8 : 4);
        cyc(1'b1, 1'b1, byte_of(seed, 0), 1'b0, '0, 8'h00, 1'b1, 8'h00, "R2 line start blank");
        text_mode = tm; pal_sel = sel;
        #1 chk("R3 byte_load at line start", {7'd0, byte_load}, 8'h01);
        cur = byte_of(seed, 0);
        k = 0;
        for (int i = 0; i < ncyc; i++) begin
            int c;
            logic ld;
            logic [7:0] nxt;
            logic we;
            logic [AW-1:0] a;
            logic [7:0] d;
            c = i % 8;
            ld = tm ? (c == 7) : ((c % 4) == 3);
            nxt = byte_of(seed, k + 1);
            we = 1'b0; a = '0; d = 8'h00;
            if (i == wa_at) begin we = 1'b1; a = wa_addr; d = wa_data; end
            if (i == wb_at) begin we = 1'b1; a = wb_addr; d = wb_data; end
            cyc(1'b0, 1'b0, ld ? nxt : ~nxt, we, a, d, 1'b1,
                shadow[mk_addr(sel, cur, c)], tag);
            #1 chk(ldtag, {7'd0, byte_load}, {7'd0, ld});
            if (ld) begin
                cur = nxt;
                k++;
            end
        end
        cyc(1'b0, 1'b1, 8'h00, tail_we, tail_addr, tail_data, 1'b1, 8'h00, "R2 blank");
        cyc(1'b0, 1'b1, 8'h00, 1'b0, '0, 8'h00, 1'b1, 8'h00, "R2 blank");
        cyc(1'b0, 1'b1, 8'h00, 1'b0, '0, 8'h00, 1'b0, 8'h00, "");
        if (wb_at >= 0) shadow[wb_addr] = wb_data;
        else if (wa_at >= 0) shadow[wa_addr] = wa_data;
        if (tail_we) shadow[tail_addr] = tail_data;
    endtask

    task automatic plain_line(input logic tm, input logic [PSEL_W-1:0] sel,
                              input int nbytes, input logic [7:0] seed, input string tag);
        run_line(tm, sel, nbytes, seed, tag, -1, '0, 8'h00, -1, '0, 8'h00, 1'b0, '0, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] sb;
        logic [7:0] old_x;
        logic [7:0] old_y;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R13 color_out after reset", color_out, 8'h00);
        chk("R13 byte_load after reset", {7'd0, byte_load}, 8'h00);

        fill_1bpp(1'b0);
        fill_8bpp(1'b1);

        plain_line(1'b1, 1'b0, 5, 8'h11, "R6 1bpp text pixel");
        plain_line(1'b0, 1'b1, 6, 8'h42, "R8 8bpp graphics pixel");
        plain_line(1'b1, 1'b1, 2, 8'h07, "R1 table select pixel");
        plain_line(1'b0, 1'b0, 4, 8'hC3, "R1 gfx on 1bpp table");

        // R9: blank write is immediate
        sb = 8'h9D;
        pal_write(mk_addr(1'b0, byte_of(sb, 0), 2), 8'hA5);
        plain_line(1'b1, 1'b0, 1, sb, "R9 immediate write");

        // R10: write during active held until blank
        sb = 8'h20;
        run_line(1'b1, 1'b0, 2, sb, "R10 held write not visible",
                 2, mk_addr(1'b0, byte_of(sb, 1), 5), 8'h3C,
                 -1, '0, 8'h00, 1'b0, '0, 8'h00);
        plain_line(1'b1, 1'b0, 2, sb, "R10 held write visible");

        // R11: later held write replaces earlier one
        sb = 8'h55;
        old_x = shadow[mk_addr(1'b0, byte_of(sb, 0), 6)];
        run_line(1'b1, 1'b0, 1, sb, "R11 line with two held writes",
                 1, mk_addr(1'b0, byte_of(sb, 0), 6), ~old_x,
                 4, mk_addr(1'b0, byte_of(sb, 0), 1), 8'h66,
                 1'b0, '0, 8'h00);
        chk("R11 model keeps earlier entry", shadow[mk_addr(1'b0, byte_of(sb, 0), 6)], old_x);
        plain_line(1'b1, 1'b0, 1, sb, "R11 replaced write");

        // R12: held write plus a write on the first blank cycle
        sb = 8'hE8;
        old_y = shadow[mk_addr(1'b0, byte_of(sb, 0), 7)];
        run_line(1'b1, 1'b0, 1, sb, "R12 line before flush",
                 3, mk_addr(1'b0, byte_of(sb, 0), 0), 8'h81,
                 -1, '0, 8'h00,
                 1'b1, mk_addr(1'b0, byte_of(sb, 0), 7), ~old_y);
        plain_line(1'b1, 1'b0, 1, sb, "R12 both writes visible");

        fill_2bpp(1'b1);
        plain_line(1'b0, 1'b1, 6, 8'h9B, "R7 2bpp graphics pixel");
        plain_line(1'b1, 1'b1, 2, 8'h3A, "R7 2bpp text pixel");

        repeat (4) @(negedge clk);
        mon_en = 1'b0;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule